// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit forms the 16-bit effective address that an 8-bit processor's execute stage needs. The mode and its operand bytes arrive already decoded. Along with the X and Y index registers, they are presented for one cycle together with a `start` pulse.

Some modes need no memory access: absolute, absolute-indexed, zero-page and zero-page-indexed. For these the address is computed at once. The three pointer modes are indirect, indexed-indirect through X and indirect-indexed through Y. For these the unit fetches a two-byte pointer through a read port that returns one byte per request. A single `done` pulse marks the cycle in which `ea` holds the result.

A variant input selects how the indirect pointer behaves when the second pointer byte sits across a page boundary. With the original behaviour, the increment of the pointer stays inside its page. With the corrected behaviour, the increment carries into the high byte, and that carry costs one idle cycle on the read port.

Top module: `agu_ea_gen`

## Requirements
- R1: In absolute mode (mode code 6), `ea` equals `op_hi`*256 + `op_lo`. `done` is high in the cycle after the clock edge that accepts `start`, and no read is requested.
- R2: Absolute-X (code 7) adds `idx_x` and absolute-Y (code 8) adds `idx_y` to the 16-bit operand address, modulo 65536. Both follow the timing of R1.
- R3: Zero-page (code 3) gives `ea` = `op_lo` with a high byte of 0. Zero-page-X (code 4) and zero-page-Y (code 5) add the index modulo 256 and keep the high byte at 0. All three follow the timing of R1.
- R4: Indexed-indirect (code 10) reads the low target byte at zero-page address (`op_lo`+`idx_x`) mod 256. It reads the high target byte at the next zero-page address, where 0xFF is followed by 0x00. `ea` is high byte*256 + low byte.
- R5: Indirect-indexed (code 11) reads the pointer low byte at zero-page address `op_lo` and the high byte at (`op_lo`+1) mod 256. `ea` is the pointer plus `idx_y`, modulo 65536. The Y value used is the one present at `start`.
- R6: Indirect (code 9) with `fixed_ptr`=0 reads the low target byte at the 16-bit operand pointer. It reads the high byte at an address with the same high byte as the pointer and a low byte of (pointer low + 1) mod 256.
- R7: Indirect with `fixed_ptr`=1 reads the high target byte at (pointer + 1) mod 65536.
- R8: Indirect with `fixed_ptr`=1 and a pointer low byte of 0xFF inserts exactly one cycle without a request between the two reads. `done` then arrives 5 cycles after the accepting edge instead of 4.
- R9: The two reads of a pointer mode are requested on consecutive cycles, low byte first, unless R8 applies. `rd_data` is taken in the cycle after each request. `done` then rises 4 cycles after the accepting edge and stays high for one cycle only.
- R10: Modes 0 (accumulator), 1 (implied), 2 (immediate) and the unused codes 12 to 15 raise `done` in the cycle after acceptance and issue no read.
- R11: `start` is ignored while `busy` is high. A request during a pointer fetch changes neither the result, the read addresses nor the latency of the fetch in progress.
- R12: Reset, asserted even in the middle of a fetch, clears `busy`, `rd_req` and `done` immediately. After reset release the unit is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to compute an address; sampled only while idle |
| mode | input | 4 | Addressing mode code |
| fixed_ptr | input | 1 | 1 selects the carrying indirect pointer, 0 the page-wrapping one |
| op_lo | input | 8 | First operand byte |
| op_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| rd_req | output | 1 | Read request for one byte |
| rd_addr | output | 16 | Address of the requested byte |
| rd_data | input | 8 | Byte returned in the cycle after the request |
| ea | output | 16 | Effective address, valid while `done` is high |
| done | output | 1 | One-cycle strobe marking a valid `ea` |
| busy | output | 1 | A pointer fetch is in progress |

## Verification
Each result has a fixed latency, counted in rising edges from the edge that accepts `start`. `done` is due after 1 edge for direct and non-memory modes, after 4 for pointer modes, and after 5 for a carrying indirect pointer that ends in 0xFF. Every scenario drives its stimulus on a falling edge and counts rising edges until `done` is seen at a falling edge. It compares that count with the expected latency, then checks that `done` has dropped one falling edge later. The bench's memory model logs each request at the falling edge where it is visible and answers on the next rising edge, so the order of the logged read addresses and any gap between them are checked as well.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [3:0] {
    AM_ACC  = 4'd0,
    AM_IMP  = 4'd1,
    AM_IMM  = 4'd2,
    AM_ZP   = 4'd3,
    AM_ZPX  = 4'd4,
    AM_ZPY  = 4'd5,
    AM_ABS  = 4'd6,
    AM_ABSX = 4'd7,
    AM_ABSY = 4'd8,
    AM_IND  = 4'd9,
    AM_INDX = 4'd10,
    AM_INDY = 4'd11
  } am_e;

  localparam int MODE_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PTR_LO = 3'd1,
    ST_GAP    = 3'd2,
    ST_PTR_HI = 3'd3,
    ST_FINISH = 3'd4
  } st_e;

endpackage

// File: rtl/agu_idx_add.sv
// Adds a zero-extended byte to an address, either with full carry or with
// the carry confined to the low byte (page wrap).
module agu_idx_add #(
  parameter  int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] idx,
  input  logic          page_wrap,
  output logic [AW-1:0] sum
);

  logic [AW-1:0] full_sum;
  logic [DW-1:0] low_sum;

  assign full_sum = base + {{(AW-DW){1'b0}}, idx};
  assign low_sum  = base[DW-1:0] + idx;
  assign sum      = page_wrap ? {base[AW-1:DW], low_sum} : full_sum;

endmodule

// File: rtl/agu_mode_dec.sv
// Per-mode selection of base, index and wrap; yields the direct address or
// the pointer location for the pointer modes.
module agu_mode_dec
  import agu_pkg::*;
#(
  parameter  int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic [MODE_W-1:0] mode,
  input  logic              fixed_ptr,
  input  logic [DW-1:0]     op_lo,
  input  logic [DW-1:0]     op_hi,
  input  logic [DW-1:0]     idx_x,
  input  logic [DW-1:0]     idx_y,
  output logic              is_ptr,
  output logic              hi_wrap,
  output logic              add_y,
  output logic [AW-1:0]     addr
);

  logic          zp_base;
  logic          wrap;
  logic [DW-1:0] idx;
  logic [AW-1:0] base;

  always_comb begin
    zp_base = 1'b0;
    wrap    = 1'b0;
    idx     = '0;
    is_ptr  = 1'b0;
    hi_wrap = 1'b1;
    add_y   = 1'b0;
    case (mode)
      AM_ZP:   begin zp_base = 1'b1; wrap = 1'b1; end
      AM_ZPX:  begin zp_base = 1'b1; wrap = 1'b1; idx = idx_x; end
      AM_ZPY:  begin zp_base = 1'b1; wrap = 1'b1; idx = idx_y; end
      AM_ABSX: idx = idx_x;
      AM_ABSY: idx = idx_y;
      AM_IND:  begin is_ptr = 1'b1; hi_wrap = ~fixed_ptr; end
      AM_INDX: begin zp_base = 1'b1; wrap = 1'b1; idx = idx_x; is_ptr = 1'b1; end
      AM_INDY: begin zp_base = 1'b1; is_ptr = 1'b1; add_y = 1'b1; end
      default: ;
    endcase
  end

  assign base = zp_base ? {{(AW-DW){1'b0}}, op_lo} : {op_hi, op_lo};

  agu_idx_add #(.DW(DW)) u_sel_add (
    .base      (base),
    .idx       (idx),
    .page_wrap (wrap),
    .sum       (addr)
  );

endmodule

// File: rtl/agu_fsm.sv
// Pointer fetch sequencer and result register.
module agu_fsm
  import agu_pkg::*;
#(
  parameter  int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_ptr,
  input  logic          hi_wrap,
  input  logic          add_y,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] idx_y,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] ea,
  output logic          done,
  output logic          busy
);

  localparam logic [DW-1:0] LOW_ALL_ONES = {DW{1'b1}};
  localparam logic [DW-1:0] ONE          = {{(DW-1){1'b0}}, 1'b1};

  st_e           state_q, state_d;
  logic [AW-1:0] ptr_q;
  logic          wrap_q, addy_q, lo_wait_q;
  logic [DW-1:0] y_q, lo_q;
  logic [AW-1:0] ea_q, ea_d;
  logic          done_q, done_d;

  logic          accept;
  logic          load_ptr;
  logic          ea_load;
  logic [AW-1:0] ptr_next;
  logic [AW-1:0] final_sum;

  agu_idx_add #(.DW(DW)) u_step_add (
    .base      (ptr_q),
    .idx       (ONE),
    .page_wrap (wrap_q),
    .sum       (ptr_next)
  );

  agu_idx_add #(.DW(DW)) u_final_add (
    .base      ({rd_data, lo_q}),
    .idx       (addy_q ? y_q : '0),
    .page_wrap (1'b0),
    .sum       (final_sum)
  );

  assign accept = start && (state_q == ST_IDLE);

  always_comb begin
    state_d  = state_q;
    load_ptr = 1'b0;
    ea_load  = 1'b0;
    ea_d     = ea_q;
    done_d   = 1'b0;
    rd_req   = 1'b0;
    rd_addr  = ptr_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (is_ptr) begin
            load_ptr = 1'b1;
            state_d  = ST_PTR_LO;
          end else begin
            ea_load = 1'b1;
            ea_d    = addr_in;
            done_d  = 1'b1;
          end
        end
      end
      ST_PTR_LO: begin
        rd_req  = 1'b1;
        rd_addr = ptr_q;
        state_d = (!wrap_q && ptr_q[DW-1:0] == LOW_ALL_ONES) ? ST_GAP : ST_PTR_HI;
      end
      ST_GAP: begin
        state_d = ST_PTR_HI;
      end
      ST_PTR_HI: begin
        rd_req  = 1'b1;
        rd_addr = ptr_next;
        state_d = ST_FINISH;
      end
      ST_FINISH: begin
        ea_load = 1'b1;
        ea_d    = final_sum;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      done_q    <= 1'b0;
      lo_wait_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      done_q    <= done_d;
      lo_wait_q <= (state_q == ST_PTR_LO);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      wrap_q <= 1'b1;
      addy_q <= 1'b0;
      y_q    <= '0;
    end else if (load_ptr) begin
      ptr_q  <= addr_in;
      wrap_q <= hi_wrap;
      addy_q <= add_y;
      y_q    <= idx_y;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (lo_wait_q) begin
      lo_q <= rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q <= '0;
    end else if (ea_load) begin
      ea_q <= ea_d;
    end
  end

  assign ea   = ea_q;
  assign done = done_q;
  assign busy = (state_q != ST_IDLE);

  // Assertions

  // R6 / R4 / R5: a page-wrapping second fetch keeps the pointer's high byte
  assert_hi_page_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && state_q == ST_PTR_HI && wrap_q) |-> (rd_addr[AW-1:DW] == ptr_q[AW-1:DW]));

  // R8: the idle gap follows a request whose low byte was all ones
  assert_gap_after_ff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GAP) |-> (!rd_req && $past(rd_req) && $past(rd_addr[DW-1:0]) == LOW_ALL_ONES));

  // R9: no completion directly after a read request
  assert_no_done_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !done);

  // R9: the read port is quiet while idle
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req);

  // R10 / R1: modes without a pointer finish next cycle with no read
  assert_direct_next_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_ptr) |=> (done && !rd_req && !busy));

  // R11: a pointer fetch in progress always reaches the next step
  assert_fetch_progress_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PTR_HI) |=> (state_q == ST_FINISH));

endmodule

// File: rtl/agu_ea_gen.sv
module agu_ea_gen
  import agu_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic              fixed_ptr,
  input  logic [DATA_W-1:0] op_lo,
  input  logic [DATA_W-1:0] op_hi,
  input  logic [DATA_W-1:0] idx_x,
  input  logic [DATA_W-1:0] idx_y,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] ea,
  output logic              done,
  output logic              busy
);

  // Asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  logic              is_ptr;
  logic              hi_wrap;
  logic              add_y;
  logic [ADDR_W-1:0] dec_addr;

  agu_mode_dec #(.DW(DATA_W)) u_dec (
    .mode      (mode),
    .fixed_ptr (fixed_ptr),
    .op_lo     (op_lo),
    .op_hi     (op_hi),
    .idx_x     (idx_x),
    .idx_y     (idx_y),
    .is_ptr    (is_ptr),
    .hi_wrap   (hi_wrap),
    .add_y     (add_y),
    .addr      (dec_addr)
  );

  agu_fsm #(.DW(DATA_W)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (start),
    .is_ptr  (is_ptr),
    .hi_wrap (hi_wrap),
    .add_y   (add_y),
    .addr_in (dec_addr),
    .idx_y   (idx_y),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .ea      (ea),
    .done    (done),
    .busy    (busy)
  );

endmodule

// File: tb/agu_ea_gen_bench.sv
`timescale 1ns/1ps
module agu_ea_gen_bench;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [3:0]  mode;
  logic        fixed_ptr;
  logic [7:0]  op_lo, op_hi, idx_x, idx_y;
  logic        rd_req;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data;
  logic [15:0] ea;
  logic        done;
  logic        busy;

  int n_chk;
  int n_fail;

  agu_ea_gen u_agu_ea_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .fixed_ptr (fixed_ptr),
    .op_lo     (op_lo),
    .op_hi     (op_hi),
    .idx_x     (idx_x),
    .idx_y     (idx_y),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .ea        (ea),
    .done      (done),
    .busy      (busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd7;
    return m ^ a[15:8] ^ 8'hA5;
  endfunction

  // Memory model: request seen at falling edge, answered on next rising edge
  logic        pend;
  logic [15:0] pend_addr;
  int          nreq;
  logic [15:0] req_log [4];

  initial begin
    pend = 1'b0;
    pend_addr = '0;
    rd_data = '0;
    nreq = 0;
  end

  always @(negedge clk) begin
    pend      = rd_req;
    pend_addr = rd_addr;
    if (rd_req) begin
      if (nreq < 4) req_log[nreq] = rd_addr;
      nreq = nreq + 1;
    end
  end

  always @(posedge clk) begin
    if (pend) rd_data <= memf(pend_addr);
  end

  task automatic chk(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Generic run: drive at a falling edge, count rising edges until done.
  task automatic run_case(input string tag, input logic [3:0] m, input logic [7:0] lo,
                          input logic [7:0] hi, input logic [7:0] x, input logic [7:0] y,
                          input logic fx, input logic poke, input logic chk_ea,
                          input logic [15:0] exp_ea, input int exp_lat, input int exp_nreq,
                          input logic [15:0] exp_a0, input logic [15:0] exp_a1);
    int lat;
    logic got;
    logic [15:0] ea_seen;
    @(negedge clk);
    nreq = 0;
    mode = m; op_lo = lo; op_hi = hi; idx_x = x; idx_y = y; fixed_ptr = fx;
    start = 1'b1;
    lat = 0;
    got = 1'b0;
    ea_seen = '0;
    while (!got && lat < 16) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (lat == 1) start = 1'b0;
      if (poke && lat == 2) begin
        start = 1'b1; mode = 4'd6; op_lo = 8'h11; op_hi = 8'h22; idx_x = 8'h00; idx_y = 8'h77;
      end
      if (poke && lat == 3) start = 1'b0;
      if (done) begin
        got = 1'b1;
        ea_seen = ea;
      end
    end
    chk({tag, " latency"}, got && lat == exp_lat, lat, exp_lat);
    if (chk_ea) chk({tag, " ea"}, ea_seen == exp_ea, ea_seen, exp_ea);
    @(negedge clk);
    chk({tag, " done one cycle R9"}, done == 1'b0, done, 0);
    chk({tag, " request count"}, nreq == exp_nreq, nreq, exp_nreq);
    if (exp_nreq >= 1) chk({tag, " first read addr"}, req_log[0] == exp_a0, req_log[0], exp_a0);
    if (exp_nreq >= 2) chk({tag, " second read addr"}, req_log[1] == exp_a1, req_log[1], exp_a1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    start = 1'b0; mode = '0; fixed_ptr = 1'b0;
    op_lo = '0; op_hi = '0; idx_x = '0; idx_y = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 reset done", done == 1'b0, done, 0);
    chk("R12 reset rd_req", rd_req == 1'b0, rd_req, 0);
    chk("R12 reset busy", busy == 1'b0, busy, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    mode = 4'd9; op_lo = 8'h40; op_hi = 8'h30; fixed_ptr = 1'b1; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R12 busy before reset", busy == 1'b1, busy, 1);
    rst_n = 1'b0;
    #1;
    chk("R12 mid-fetch reset busy", busy == 1'b0, busy, 0);
    chk("R12 mid-fetch reset rd_req", rd_req == 1'b0, rd_req, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R12 idle after release", busy == 1'b0 && done == 1'b0, {busy, done}, 0);
  endtask

  task automatic t_absolute;
    run_case("R1 abs", 4'd6, 8'h34, 8'h12, 8'h55, 8'h66, 1'b0, 1'b0, 1'b1, 16'h1234, 1, 0, 0, 0);
    run_case("R1 abs high", 4'd6, 8'h01, 8'hFE, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 16'hFE01, 1, 0, 0, 0);
  endtask

  task automatic t_abs_indexed;
    run_case("R2 absx wrap", 4'd7, 8'hF0, 8'hFF, 8'h20, 8'h01, 1'b0, 1'b0, 1'b1, 16'h0010, 1, 0, 0, 0);
    run_case("R2 absy carry", 4'd8, 8'hF0, 8'h10, 8'h03, 8'h15, 1'b0, 1'b0, 1'b1, 16'h1105, 1, 0, 0, 0);
  endtask

  task automatic t_zero_page;
    run_case("R3 zp", 4'd3, 8'h80, 8'h99, 8'h01, 8'h01, 1'b0, 1'b0, 1'b1, 16'h0080, 1, 0, 0, 0);
    run_case("R3 zpx wrap", 4'd4, 8'hF0, 8'h99, 8'h20, 8'h01, 1'b0, 1'b0, 1'b1, 16'h0010, 1, 0, 0, 0);
    run_case("R3 zpy", 4'd5, 8'h10, 8'h99, 8'hFF, 8'h05, 1'b0, 1'b0, 1'b1, 16'h0015, 1, 0, 0, 0);
  endtask

  task automatic t_indx;
    run_case("R4 indx wrap", 4'd10, 8'hF0, 8'h77, 8'h0F, 8'h44, 1'b1, 1'b0, 1'b1,
             {memf(16'h0000), memf(16'h00FF)}, 4, 2, 16'h00FF, 16'h0000);
    run_case("R4 indx plain", 4'd10, 8'h20, 8'h77, 8'h04, 8'h44, 1'b0, 1'b0, 1'b1,
             {memf(16'h0025), memf(16'h0024)}, 4, 2, 16'h0024, 16'h0025);
  endtask

  task automatic t_indy;
    logic [15:0] p;
    p = {memf(16'h0000), memf(16'h00FF)} + 16'h0010;
    run_case("R5 indy zp wrap", 4'd11, 8'hFF, 8'h55, 8'h01, 8'h10, 1'b1, 1'b0, 1'b1,
             p, 4, 2, 16'h00FF, 16'h0000);
    p = {memf(16'h0031), memf(16'h0030)} + 16'h00F0;
    run_case("R5 indy", 4'd11, 8'h30, 8'h55, 8'h01, 8'hF0, 1'b0, 1'b0, 1'b1,
             p, 4, 2, 16'h0030, 16'h0031);
  endtask

  task automatic t_ind_defect;
    run_case("R6 ind page wrap", 4'd9, 8'hFF, 8'h20, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1,
             {memf(16'h2000), memf(16'h20FF)}, 4, 2, 16'h20FF, 16'h2000);
    run_case("R6 ind no cross", 4'd9, 8'h40, 8'h30, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1,
             {memf(16'h3041), memf(16'h3040)}, 4, 2, 16'h3040, 16'h3041);
  endtask

  task automatic t_ind_fixed;
    run_case("R7 R8 ind carry", 4'd9, 8'hFF, 8'h20, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1,
             {memf(16'h2100), memf(16'h20FF)}, 5, 2, 16'h20FF, 16'h2100);
    run_case("R7 ind top wrap", 4'd9, 8'hFF, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1,
             {memf(16'h0000), memf(16'hFFFF)}, 5, 2, 16'hFFFF, 16'h0000);
    run_case("R8 R9 ind fixed no gap", 4'd9, 8'h40, 8'h30, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1,
             {memf(16'h3041), memf(16'h3040)}, 4, 2, 16'h3040, 16'h3041);
  endtask

  task automatic t_nonmem;
    run_case("R10 accumulator", 4'd0, 8'h12, 8'h34, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 0, 1, 0, 0, 0);
    run_case("R10 implied", 4'd1, 8'h12, 8'h34, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 0, 1, 0, 0, 0);
    run_case("R10 immediate", 4'd2, 8'h12, 8'h34, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 0, 1, 0, 0, 0);
    run_case("R10 unused code", 4'd14, 8'h12, 8'h34, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 0, 1, 0, 0, 0);
  endtask

  task automatic t_busy_ignore;
    logic [15:0] p;
    p = {memf(16'h0051), memf(16'h0050)} + 16'h0003;
    run_case("R11 start while busy", 4'd11, 8'h50, 8'h00, 8'h00, 8'h03, 1'b0, 1'b1, 1'b1,
             p, 4, 2, 16'h0050, 16'h0051);
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    t_reset();
    t_absolute();
    t_abs_indexed();
    t_zero_page();
    t_indx();
    t_indy();
    t_ind_defect();
    t_ind_fixed();
    t_nonmem();
    t_busy_ignore();
    t_reset_mid();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule